// File: doc/BRIEF.md
# Peripheral and Master-Port Idle Gating Unit

This unit keeps two writable control registers. One holds one idle-request bit for each of up to fourteen peripheral slots. The other holds one bit each for the DMA engine and the host port. From these registers it derives per-module idle status bits, and those bits drive the clock-gating cells outside the unit. The domain controller supplies two status levels: `pdom_idle` for the peripheral domain and `mdom_idle` for the master-port domain. An idle strobe marks the point at which a new idle configuration takes effect.

A peripheral slot idles only if three things hold when the strobe comes: its control bit is set, the peripheral domain reports idle, and the slot later acknowledges with its `slot_ack` input. The acknowledge step lets a transfer-type peripheral finish its current transaction first. A strobe while the domain is awake wakes every slot, whatever the control bits say. Writing 0 to a single control bit wakes that one module at once. The master modules idle on a rising edge of the master-port domain status, and all of them wake when that status falls.

Top module: `idle_gate_unit`

## Requirements
- R1: After a synchronous reset, both control registers and both status registers read 0.
- R2: A write with `wr_sel`=0 loads peripheral control bits 13..0, and a write with `wr_sel`=1 loads master control bits 1..0 (bit0 DMA, bit1 host port). All other bits of both control registers ignore writes and read 0.
- R3: A slot's status bit (same bit position as its control bit) goes to 1 only at the first clock edge at which it samples `slot_ack` high. That edge must come after the edge that sampled `idle_strobe` with `pdom_idle`=1 and the slot's control bit at 1.
- R4: A slot whose idle request is pending stays awake for as long as its `slot_ack` is low.
- R5: A slot whose control bit is 0 never idles, even with `slot_ack` high and a strobe while the domain is idle.
- R6: A strobe sampled with `pdom_idle`=0 clears every peripheral status bit at that edge, regardless of the control bits.
- R7: A strobe with `pdom_idle`=1 leaves already idled slots idle, provided their control bit is still 1.
- R8: A peripheral write that carries 0 in a slot's bit clears that slot's status at the write edge, with no strobe needed. Slots written with 1 keep their status.
- R9: At the edge that first samples `mdom_idle` high after it was low, each master status bit takes the value of its control bit.
- R10: A master write that carries 0 in a bit clears that master's status at the write edge. The other master is not affected.
- R11: At the edge that first samples `mdom_idle` low after it was high, both master status bits clear.
- R12: A strobe with `pdom_idle`=0 cancels any pending slot request, so a later acknowledge does not idle the slot.
- R13: Setting a master control bit while `mdom_idle` is already high does not idle that master until the next rising edge of `mdom_idle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write enable |
| wr_sel | input | 1 | 0 selects peripheral control, 1 selects master control |
| wr_data | input | 16 | Write data |
| idle_strobe | input | 1 | One-cycle idle instruction strobe |
| pdom_idle | input | 1 | Peripheral-domain idle status from the domain controller |
| mdom_idle | input | 1 | Master-port-domain idle status from the domain controller |
| slot_ack | input | 14 | Per-slot idle acknowledge |
| periph_ctl | output | 16 | Peripheral control readback |
| periph_stat | output | 16 | Peripheral idle status (1 = disabled) |
| mast_ctl | output | 16 | Master control readback |
| mast_stat | output | 16 | Master idle status (1 = disabled) |

## Verification
The hardest case to reach is a pending slot request that is withdrawn before the slot acknowledges. From the ports it looks the same as a slot that never asked to idle. The stimulus first holds `slot_ack` low through a strobe with the domain idle, so that the request is pending. It then issues a strobe with the domain awake, and only after that raises every acknowledge. The status bit must stay low. A second case needs an ordering: a master bit is set while `mdom_idle` is already high, and the stimulus then drops `mdom_idle` and raises it again.

// File: rtl/idle_gate_pkg.sv
package idle_gate_pkg;
  localparam logic SEL_PERIPH = 1'b0;
  localparam logic SEL_MASTER = 1'b1;
endpackage

// File: rtl/idle_gate_ctlreg.sv
module idle_gate_ctlreg #(
  parameter int NB = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [NB-1:0] wdata,
  output logic [NB-1:0] q,
  output logic [NB-1:0] clr
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (wr) q <= wdata;
  end

  // bits written as zero request an immediate wake of their module
  assign clr = wr ? ~wdata : '0;
endmodule

// File: rtl/idle_gate_slot.sv
module idle_gate_slot (
  input  logic clk,
  input  logic rst,
  input  logic ctl,
  input  logic clr,
  input  logic strobe,
  input  logic dom_idle,
  input  logic ack,
  output logic stat
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= 1'b0;
      pend <= 1'b0;
    end else if (strobe && !dom_idle) begin
      // domain awake at the strobe: wake, ignore own control bit
      stat <= 1'b0;
      pend <= 1'b0;
    end else if (clr) begin
      stat <= 1'b0;
      pend <= 1'b0;
    end else if (strobe) begin
      if (!ctl) begin
        stat <= 1'b0;
        pend <= 1'b0;
      end else if (!stat) begin
        pend <= 1'b1;
      end
    end else if (pend && ack) begin
      stat <= 1'b1;
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/idle_gate_master.sv
module idle_gate_master #(
  parameter int NM = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dom_idle,
  input  logic [NM-1:0] ctl,
  input  logic [NM-1:0] clr,
  output logic [NM-1:0] stat
);
  logic dom_q;
  logic dom_rise, dom_fall;

  assign dom_rise = dom_idle & ~dom_q;
  assign dom_fall = ~dom_idle & dom_q;

  always_ff @(posedge clk) begin
    if (rst) dom_q <= 1'b0;
    else     dom_q <= dom_idle;
  end

  for (genvar m = 0; m < NM; m++) begin : g_mast
    always_ff @(posedge clk) begin
      if (rst)                  stat[m] <= 1'b0;
      else if (dom_fall)        stat[m] <= 1'b0;
      else if (clr[m])          stat[m] <= 1'b0;
      else if (dom_rise)        stat[m] <= ctl[m];
    end
  end
endmodule

// File: rtl/idle_gate_unit.sv
module idle_gate_unit
  import idle_gate_pkg::*;
#(
  parameter int NSLOT = 14,
  parameter int NMAST = 2,
  parameter int RW    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [RW-1:0]    wr_data,
  input  logic             idle_strobe,
  input  logic             pdom_idle,
  input  logic             mdom_idle,
  input  logic [NSLOT-1:0] slot_ack,
  output logic [RW-1:0]    periph_ctl,
  output logic [RW-1:0]    periph_stat,
  output logic [RW-1:0]    mast_ctl,
  output logic [RW-1:0]    mast_stat
);
  localparam int PPAD = RW - NSLOT;
  localparam int MPAD = RW - NMAST;

  logic [NSLOT-1:0] pctl_q, pclr, pstat_q;
  logic [NMAST-1:0] mctl_q, mclr, mstat_q;
  logic             unused_hi;

  assign unused_hi = ^wr_data[RW-1:NSLOT];

  idle_gate_ctlreg #(.NB(NSLOT)) u_pctl (
    .clk(clk), .rst(rst),
    .wr(wr_en && (wr_sel == SEL_PERIPH)),
    .wdata(wr_data[NSLOT-1:0]),
    .q(pctl_q), .clr(pclr)
  );

  idle_gate_ctlreg #(.NB(NMAST)) u_mctl (
    .clk(clk), .rst(rst),
    .wr(wr_en && (wr_sel == SEL_MASTER)),
    .wdata(wr_data[NMAST-1:0]),
    .q(mctl_q), .clr(mclr)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    idle_gate_slot u_slot (
      .clk(clk), .rst(rst),
      .ctl(pctl_q[s]), .clr(pclr[s]),
      .strobe(idle_strobe), .dom_idle(pdom_idle),
      .ack(slot_ack[s]), .stat(pstat_q[s])
    );
  end

  idle_gate_master #(.NM(NMAST)) u_mast (
    .clk(clk), .rst(rst), .dom_idle(mdom_idle),
    .ctl(mctl_q), .clr(mclr), .stat(mstat_q)
  );

  assign periph_ctl  = {{PPAD{1'b0}}, pctl_q};
  assign periph_stat = {{PPAD{1'b0}}, pstat_q};
  assign mast_ctl    = {{MPAD{1'b0}}, mctl_q};
  assign mast_stat   = {{MPAD{1'b0}}, mstat_q};
endmodule

// File: rtl/idle_gate_chk.sv
module idle_gate_chk #(
  parameter int NSLOT = 14,
  parameter int NMAST = 2,
  parameter int RW    = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [RW-1:0]    wr_data,
  input logic             idle_strobe,
  input logic             pdom_idle,
  input logic             mdom_idle,
  input logic [NSLOT-1:0] slot_ack,
  input logic [RW-1:0]    periph_ctl,
  input logic [RW-1:0]    periph_stat,
  input logic [RW-1:0]    mast_ctl,
  input logic [RW-1:0]    mast_stat
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    disable iff (rst) $past(rst) |-> (periph_stat == '0 && mast_stat == '0))
    else $error("R1 status not clear after reset");

  assert_reserved_zero_R2: assert property (@(posedge clk)
    disable iff (rst) periph_ctl[RW-1:NSLOT] == '0 && mast_ctl[RW-1:NMAST] == '0
      && periph_stat[RW-1:NSLOT] == '0 && mast_stat[RW-1:NMAST] == '0)
    else $error("R2 reserved bit set");

  for (genvar s = 0; s < NSLOT; s++) begin : g_chk
    assert_idle_needs_ack_R3: assert property (@(posedge clk)
      disable iff (rst) $rose(periph_stat[s]) |-> $past(slot_ack[s]) && $past(periph_ctl[s]))
      else $error("R3 slot idled without acknowledge or control bit");
  end

  assert_domain_wake_R6: assert property (@(posedge clk)
    disable iff (rst) (idle_strobe && !pdom_idle) |=> periph_stat == '0)
    else $error("R6 slot still idle after domain wake");

  assert_bit_wake_R8: assert property (@(posedge clk)
    disable iff (rst) (wr_en && !wr_sel) |=>
      (periph_stat[NSLOT-1:0] & ~$past(wr_data[NSLOT-1:0])) == '0)
    else $error("R8 cleared slot still idle");

  assert_bit_wake_R10: assert property (@(posedge clk)
    disable iff (rst) (wr_en && wr_sel) |=>
      (mast_stat[NMAST-1:0] & ~$past(wr_data[NMAST-1:0])) == '0)
    else $error("R10 cleared master still idle");

  assert_master_fall_R11: assert property (@(posedge clk)
    disable iff (rst) $fell(mdom_idle) |=> mast_stat == '0)
    else $error("R11 master still idle after domain wake");

  for (genvar m = 0; m < NMAST; m++) begin : g_mchk
    assert_master_rise_R13: assert property (@(posedge clk)
      disable iff (rst) $rose(mast_stat[m]) |-> $past(mdom_idle))
      else $error("R13 master idled without domain idle");
  end
endmodule

bind idle_gate_unit idle_gate_chk #(.NSLOT(NSLOT), .NMAST(NMAST), .RW(RW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .idle_strobe(idle_strobe), .pdom_idle(pdom_idle), .mdom_idle(mdom_idle),
  .slot_ack(slot_ack), .periph_ctl(periph_ctl), .periph_stat(periph_stat),
  .mast_ctl(mast_ctl), .mast_stat(mast_stat)
);

// File: tb/idle_gate_unit_test.sv
module idle_gate_unit_test;
  localparam int CLK_P = 10;

  typedef struct {
    string       tag;
    logic [15:0] pc, ps, mc, ms;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        idle_strobe = 1'b0, pdom_idle = 1'b0, mdom_idle = 1'b0;
  logic [13:0] slot_ack = '0;
  logic [15:0] periph_ctl, periph_stat, mast_ctl, mast_stat;

  int   total = 0, bad = 0;
  bit   done = 0;
  exp_t sb[$];
  logic [15:0] epc = '0, eps = '0, emc = '0, ems = '0;

  always #(CLK_P/2) clk = ~clk;

  idle_gate_unit uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .idle_strobe(idle_strobe), .pdom_idle(pdom_idle), .mdom_idle(mdom_idle),
    .slot_ack(slot_ack), .periph_ctl(periph_ctl), .periph_stat(periph_stat),
    .mast_ctl(mast_ctl), .mast_stat(mast_stat)
  );

  // driver: one clock edge, then queue the expected state for that edge
  task automatic cyc(input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    e.tag = tag; e.pc = epc; e.ps = eps; e.mc = emc; e.ms = ems;
    sb.push_back(e);
    wr_en = 1'b0;
    idle_strobe = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (periph_ctl !== e.pc || periph_stat !== e.ps ||
            mast_ctl !== e.mc || mast_stat !== e.ms) begin
          bad++;
          $display("FAIL %s: act pc=%h ps=%h mc=%h ms=%h exp pc=%h ps=%h mc=%h ms=%h",
                   e.tag, periph_ctl, periph_stat, mast_ctl, mast_stat,
                   e.pc, e.ps, e.mc, e.ms);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    cyc("R1");
    wr(0, 16'hFFFF); epc = 16'h3FFF; cyc("R2");
    wr(1, 16'hFFFF); emc = 16'h0003; cyc("R2");
    wr(0, 16'h1005); epc = 16'h1005; cyc("R2");
    // request idle, hold acknowledge low
    pdom_idle = 1'b1; idle_strobe = 1'b1; cyc("R4");
    cyc("R4"); cyc("R4");
    slot_ack = 14'h0001; eps = 16'h0001; cyc("R3");
    slot_ack = 14'h1004; eps = 16'h1005; cyc("R3");
    slot_ack = 14'h3FFF; cyc("R5");
    idle_strobe = 1'b1; cyc("R7");
    cyc("R5");
    wr(0, 16'h1001); epc = 16'h1001; eps = 16'h1001; cyc("R8");
    pdom_idle = 1'b0; idle_strobe = 1'b1; eps = 16'h0000; cyc("R6");
    // pending request withdrawn before acknowledge
    slot_ack = '0; pdom_idle = 1'b1; idle_strobe = 1'b1; cyc("R12");
    pdom_idle = 1'b0; idle_strobe = 1'b1; cyc("R12");
    pdom_idle = 1'b1; slot_ack = 14'h3FFF; cyc("R12");
    cyc("R12");
    // master port
    wr(1, 16'h0002); emc = 16'h0002; cyc("R2");
    mdom_idle = 1'b1; ems = 16'h0002; cyc("R9");
    cyc("R9");
    wr(1, 16'h0003); emc = 16'h0003; cyc("R13");
    cyc("R13");
    mdom_idle = 1'b0; ems = 16'h0000; cyc("R11");
    mdom_idle = 1'b1; ems = 16'h0003; cyc("R9");
    wr(1, 16'h0001); emc = 16'h0001; ems = 16'h0001; cyc("R10");
    mdom_idle = 1'b0; ems = 16'h0000; cyc("R11");
    @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: act running exp finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule